// File: doc/BRIEF.md
# Flash Command Decoder with Block Locks

This block is the device side of a parallel NOR-style flash command port. Each bus write is decoded as a command byte, taken from the low eight bits of the write data. Some commands take effect in that single write. Others open a second cycle that must carry a confirm code or the data word to be stored.

Earlier command writes set a read mode, and that mode decides what a bus read returns:
- the storage array,
- the status byte, zero-extended to the data width,
- identification words, including the lock state of the addressed block.

Program and erase act on an internal RAM array that starts as all ones. Programming can only clear bits. Erase restores a whole block to all ones. Each operation holds the device busy for a time set by a parameter.

A program or erase aimed at a locked block does not change the array. A malformed command sequence is not silently dropped either. Both cases are recorded in sticky error bits of the status byte, which are also driven on a dedicated output.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset:
  - the status output is 0x80 (ready, no errors);
  - reads return array data;
  - every array word reads as all ones;
  - every block is locked (with the default LOCK_AT_RESET = 1).
- R2: A read request with `rd_en` high in cycle t produces `rd_data` with `rd_valid` high in cycle t+2. `rd_valid` is low two cycles after any cycle without a request.
- R3: Command 0xFF selects array reads. Command 0x70 selects status reads, where `rd_data` holds the status byte in bits 7:0 and zeros above. The status layout is:
  - bit 7: ready;
  - bit 5: erase error;
  - bit 4: program error;
  - bit 3: supply error (always 0 here);
  - bit 1: lock violation.
- R4: Command 0x90 selects identification reads. The offset is the low BLK_OFF_W address bits:
  - offset 0 returns MFR_CODE;
  - offset 1 returns DEV_CODE;
  - offset 2 returns the addressed block's lock word (bit 0 locked, bit 1 locked down);
  - any other offset returns 0.
- R5: Command 0x60 followed by a second write to the target block acts on that block's lock:
  - 0xD0 unlocks it;
  - 0x01 locks it;
  - 0x2F locks it down (and locks it).
  
  A locked-down block ignores unlock until reset.
- R6: Command 0x10 followed by a data write to address A programs A. The new content is the old content AND the data.
- R7: Command 0x20 followed by 0xD0 written to an address in a block erases the block: every word of that block becomes all ones, and other blocks are unchanged.
- R8: While an operation is running, status bit 7 reads 0 and every read returns the status byte.
  - A program keeps bit 7 at 0 for max(BUSY_CYC,2) cycles.
  - An erase keeps it at 0 for 2^BLK_OFF_W + max(BUSY_CYC,2) cycles.
  
  After a setup or second cycle, reads stay in status mode until another mode command.
- R9: Bus writes that arrive while an operation is running are ignored: they change neither mode nor status nor array.
- R10: A program or erase aimed at a locked block leaves the array unchanged. It starts no busy period, and sets bit 1 together with bit 4 (program) or bit 5 (erase).
- R11: A second cycle after 0x20 that is not 0xD0, or after 0x60 that is not 0xD0, 0x01 or 0x2F, sets bits 4 and 5 and returns the decoder to idle.
- R12: Error bits are sticky. Of the commands, only 0x50, written as a single command while idle, clears them, and it leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command byte |
| rd_en | input | 1 | Bus read request |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | DATA_W | Read result, registered |
| rd_valid | output | 1 | Marks `rd_data` valid, two cycles after `rd_en` |
| status_o | output | 8 | Live status byte (ready and sticky error bits) |

## Verification
The bench targets these corner cases:
- **AND rule.** It programs a word twice. A design that overwrote instead of ANDing would return the second data instead of 0x0A30.
- **Busy period.** It measures the exact length of the busy window for program and erase. While busy, it reads and also writes 0xFF. A decoder that honoured that write would return array data, not status, once the operation ends.
- **Locked and locked-down blocks.** It aims operations at these blocks and checks that stored data survives. It also tries to unlock a locked-down block.
- **Bad confirm codes.** After a bad confirm, a following 0x50 must clear the errors. That shows the decoder really fell back to idle rather than taking 0x50 as a second cycle.
- **Random traffic.** Seeded random programs and erases over unlocked blocks are compared with a bench model of the array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_IDENT,
    RM_STATUS
  } rd_mode_e;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_LOCK_CF,
    CS_ERASE_CF,
    CS_PROG_DATA
  } cmd_state_e;

  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_IDENT  = 8'h90;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;
  localparam logic [7:0] OP_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] OP_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] OP_LOCK_SET    = 8'h01;
  localparam logic [7:0] OP_LOCK_DOWN   = 8'h2F;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h10;

endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Erased state at power-up: all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_lock_table.sv
module flash_lock_table #(
  parameter int BLK_W         = 4,
  parameter bit LOCK_AT_RESET = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BLK_W-1:0]    blk,
  input  logic                do_unlock,
  input  logic                do_lock,
  input  logic                do_ldown,
  output logic [(1<<BLK_W)-1:0] locked,
  output logic [(1<<BLK_W)-1:0] ldown
);
  localparam int NBLK = 1 << BLK_W;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic lk_q, ld_q;
    logic hit;
    assign hit = (blk == BLK_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        lk_q <= LOCK_AT_RESET;
        ld_q <= 1'b0;
      end else if (hit) begin
        if (do_ldown) begin
          lk_q <= 1'b1;
          ld_q <= 1'b1;
        end else if (do_lock) begin
          lk_q <= 1'b1;
        end else if (do_unlock && !ld_q) begin
          lk_q <= 1'b0;
        end
      end
    end

    assign locked[g] = lk_q;
    assign ldown[g]  = ld_q;
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BLK_OFF_W = 4,
  parameter int BUSY_CYC  = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [(1<<(ADDR_W-BLK_OFF_W))-1:0] locked_vec,
  input  logic [DATA_W-1:0]              mem_q,
  output rd_mode_e                       mode,
  output logic                           busy,
  output logic [7:0]                     status,
  output logic [ADDR_W-BLK_OFF_W-1:0]    lk_blk,
  output logic                           lk_unlock,
  output logic                           lk_lock,
  output logic                           lk_ldown,
  output logic                           mem_we,
  output logic [ADDR_W-1:0]              mem_waddr,
  output logic [DATA_W-1:0]              mem_wdata,
  output logic [ADDR_W-1:0]              op_addr
);
  localparam int BLK_W     = ADDR_W - BLK_OFF_W;
  localparam int BLK_WORDS = 1 << BLK_OFF_W;
  localparam int PROG_DUR  = (BUSY_CYC < 2) ? 2 : BUSY_CYC;
  localparam int ERASE_DUR = BLK_WORDS + PROG_DUR;
  localparam int CNT_W     = $clog2(ERASE_DUR + 1);

  cmd_state_e            st_q;
  rd_mode_e              mode_q;
  logic                  busy_q, op_erase_q, wipe_on_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BLK_OFF_W-1:0]  wipe_idx_q;
  logic [ADDR_W-1:0]     op_addr_q;
  logic [DATA_W-1:0]     op_data_q;
  logic                  err_e_q, err_p_q, err_l_q;

  logic [7:0]       cmd;
  logic             take;
  logic [BLK_W-1:0] wr_blk;
  logic             tgt_locked;

  assign cmd        = wr_data[7:0];
  assign take       = wr_en && !busy_q;
  assign wr_blk     = wr_addr[ADDR_W-1:BLK_OFF_W];
  assign tgt_locked = locked_vec[wr_blk];

  assign lk_blk    = wr_blk;
  assign lk_unlock = take && (st_q == CS_LOCK_CF) && (cmd == OP_CONFIRM);
  assign lk_lock   = take && (st_q == CS_LOCK_CF) && (cmd == OP_LOCK_SET);
  assign lk_ldown  = take && (st_q == CS_LOCK_CF) && (cmd == OP_LOCK_DOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= CS_IDLE;
      mode_q     <= RM_ARRAY;
      busy_q     <= 1'b0;
      op_erase_q <= 1'b0;
      wipe_on_q  <= 1'b0;
      cnt_q      <= '0;
      wipe_idx_q <= '0;
      op_addr_q  <= '0;
      op_data_q  <= '0;
      err_e_q    <= 1'b0;
      err_p_q    <= 1'b0;
      err_l_q    <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (wipe_on_q) begin
        wipe_idx_q <= wipe_idx_q + 1'b1;
        if (&wipe_idx_q) wipe_on_q <= 1'b0;
      end
    end else if (wr_en) begin
      unique case (st_q)
        CS_IDLE: begin
          unique case (cmd)
            OP_READ_ARRAY:  mode_q <= RM_ARRAY;
            OP_READ_IDENT:  mode_q <= RM_IDENT;
            OP_READ_STATUS: mode_q <= RM_STATUS;
            OP_CLEAR_ERR: begin
              err_e_q <= 1'b0;
              err_p_q <= 1'b0;
              err_l_q <= 1'b0;
            end
            OP_LOCK_SETUP: begin
              st_q   <= CS_LOCK_CF;
              mode_q <= RM_STATUS;
            end
            OP_ERASE_SETUP: begin
              st_q   <= CS_ERASE_CF;
              mode_q <= RM_STATUS;
            end
            OP_PROG_SETUP: begin
              st_q   <= CS_PROG_DATA;
              mode_q <= RM_STATUS;
            end
            default: ;
          endcase
        end
        CS_LOCK_CF: begin
          st_q   <= CS_IDLE;
          mode_q <= RM_STATUS;
          if (!(cmd == OP_CONFIRM || cmd == OP_LOCK_SET || cmd == OP_LOCK_DOWN)) begin
            err_p_q <= 1'b1;
            err_e_q <= 1'b1;
          end
        end
        CS_ERASE_CF: begin
          st_q   <= CS_IDLE;
          mode_q <= RM_STATUS;
          if (cmd != OP_CONFIRM) begin
            err_p_q <= 1'b1;
            err_e_q <= 1'b1;
          end else if (tgt_locked) begin
            err_l_q <= 1'b1;
            err_e_q <= 1'b1;
          end else begin
            busy_q     <= 1'b1;
            cnt_q      <= CNT_W'(ERASE_DUR - 1);
            op_erase_q <= 1'b1;
            op_addr_q  <= wr_addr;
            wipe_on_q  <= 1'b1;
            wipe_idx_q <= '0;
          end
        end
        CS_PROG_DATA: begin
          st_q   <= CS_IDLE;
          mode_q <= RM_STATUS;
          if (tgt_locked) begin
            err_l_q <= 1'b1;
            err_p_q <= 1'b1;
          end else begin
            busy_q     <= 1'b1;
            cnt_q      <= CNT_W'(PROG_DUR - 1);
            op_erase_q <= 1'b0;
            op_addr_q  <= wr_addr;
            op_data_q  <= wr_data;
          end
        end
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  // Program: read-modify-write at the last busy cycle, the read port having
  // been pointed at op_addr since the cycle after acceptance.
  // Erase: one word of the block per cycle at the start of the busy window.
  assign mem_we    = busy_q && (op_erase_q ? wipe_on_q : (cnt_q == '0));
  assign mem_waddr = op_erase_q ? {op_addr_q[ADDR_W-1:BLK_OFF_W], wipe_idx_q} : op_addr_q;
  assign mem_wdata = op_erase_q ? '1 : (mem_q & op_data_q);

  assign mode    = mode_q;
  assign busy    = busy_q;
  assign op_addr = op_addr_q;
  assign status  = {~busy_q, 1'b0, err_e_q, err_p_q, 1'b0, 1'b0, err_l_q, 1'b0};
endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter int              DATA_W        = 16,
  parameter int              BLK_OFF_W     = 4,
  parameter int              BUSY_CYC      = 6,
  parameter bit              LOCK_AT_RESET = 1'b1,
  parameter logic [DATA_W-1:0] MFR_CODE    = 16'h00A5,
  parameter logic [DATA_W-1:0] DEV_CODE    = 16'h5C31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [7:0]        status_o
);
  localparam int BLK_W = ADDR_W - BLK_OFF_W;
  localparam int NBLK  = 1 << BLK_W;

  rd_mode_e          mode;
  logic              busy;
  logic [7:0]        status;
  logic [BLK_W-1:0]  lk_blk;
  logic              lk_unlock, lk_lock, lk_ldown;
  logic [NBLK-1:0]   locked_vec, ldown_vec;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr, op_addr;
  logic [DATA_W-1:0] mem_wdata, mem_q;

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_OFF_W(BLK_OFF_W), .BUSY_CYC(BUSY_CYC)
  ) fsm_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .locked_vec(locked_vec), .mem_q(mem_q), .mode(mode), .busy(busy),
    .status(status), .lk_blk(lk_blk), .lk_unlock(lk_unlock), .lk_lock(lk_lock),
    .lk_ldown(lk_ldown), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .op_addr(op_addr)
  );

  flash_lock_table #(.BLK_W(BLK_W), .LOCK_AT_RESET(LOCK_AT_RESET)) locks_i (
    .clk(clk), .rst(rst), .blk(lk_blk), .do_unlock(lk_unlock), .do_lock(lk_lock),
    .do_ldown(lk_ldown), .locked(locked_vec), .ldown(ldown_vec)
  );

  assign mem_raddr = busy ? op_addr : rd_addr;

  flash_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  // Identification word for the current read address
  logic [BLK_W-1:0]     rd_blk;
  logic [BLK_OFF_W-1:0] rd_off;
  logic [DATA_W-1:0]    id_word;

  assign rd_blk = rd_addr[ADDR_W-1:BLK_OFF_W];
  assign rd_off = rd_addr[BLK_OFF_W-1:0];

  always_comb begin
    id_word = '0;
    if (rd_off == BLK_OFF_W'(0))      id_word = MFR_CODE;
    else if (rd_off == BLK_OFF_W'(1)) id_word = DEV_CODE;
    else if (rd_off == BLK_OFF_W'(2)) id_word[1:0] = {ldown_vec[rd_blk], locked_vec[rd_blk]};
  end

  // Two-stage read pipeline: stage 1 captures the source, stage 2 the result
  logic              v1_q, sel_arr_q;
  logic [DATA_W-1:0] side_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      sel_arr_q <= 1'b0;
      side_q    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      v1_q      <= rd_en;
      sel_arr_q <= !busy && (mode == RM_ARRAY);
      side_q    <= (busy || mode == RM_STATUS) ? DATA_W'(status) : id_word;
      rd_valid  <= v1_q;
      if (v1_q) rd_data <= sel_arr_q ? mem_q : side_q;
    end
  end

  assign status_o = status;
endmodule

// File: rtl/flash_cmd_ui_chk.sv
module flash_cmd_ui_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [7:0]        status_o
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_data[7:0] == 8'h50);

  assert_rd_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rd_valid);

  assert_rd_idle_lat_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> ##2 !rd_valid);

  assert_busy_reads_status_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !status_o[7]) |-> ##2 (rd_data[7] == 1'b0 && rd_data[DATA_W-1:8] == '0));

  assert_busy_min_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(status_o[7]) |=> !status_o[7]);

  assert_busy_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !status_o[7] |=> $stable(status_o[6:0]));

  assert_prog_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (status_o[4] && !clr_wr) |=> status_o[4]);

  assert_erase_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (status_o[5] && !clr_wr) |=> status_o[5]);

  assert_lock_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (status_o[1] && !clr_wr) |=> status_o[1]);
endmodule

bind flash_cmd_ui flash_cmd_ui_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_data(rd_data), .status_o(status_o)
);

// File: tb/flash_cmd_ui_tb.sv
module flash_cmd_ui_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int BLK_OFF_W  = 4;
  localparam int BUSY_CYC   = 6;
  localparam logic [15:0] MFR = 16'h00A5;
  localparam logic [15:0] DEV = 16'h5C31;
  localparam int PROG_DUR   = 6;
  localparam int ERASE_DUR  = 16 + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_valid;
  logic [7:0] status_o;

  int checks = 0;
  int bad = 0;
  logic [15:0] mdl [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ui #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_OFF_W(BLK_OFF_W), .BUSY_CYC(BUSY_CYC),
    .LOCK_AT_RESET(1'b1), .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .status_o(status_o)
  );

  function automatic logic [7:0] exp_status(bit rdy, bit ee, bit pe, bit le);
    return {rdy, 1'b0, ee, pe, 1'b0, 1'b0, le, 1'b0};
  endfunction

  function automatic logic [15:0] exp_lockword(bit lk, bit ld);
    return {14'b0, ld, lk};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b1) begin
      bad++;
      $display("FAIL R2: actual=%b expected=1", rd_valid);
    end
    v = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (status_o[7] !== 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", checks, bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", {8'h0, status_o}, {8'h0, exp_status(1, 0, 0, 0)});
    chk("R1 rd_valid idle", {15'b0, rd_valid}, 16'h0);
    rd(8'h05, v); chk("R1 array blank", v, 16'hFFFF);
    rd(8'hF3, v); chk("R1 array blank hi", v, 16'hFFFF);

    // R4 identification
    wr(8'h00, 16'h0090);
    rd(8'h00, v); chk("R4 mfr", v, MFR);
    rd(8'h31, v); chk("R4 dev", v, DEV);
    rd(8'h32, v); chk("R1 R4 locked at reset", v, exp_lockword(1, 0));
    rd(8'h37, v); chk("R4 other offset", v, 16'h0000);

    // R3 status mode
    wr(8'h00, 16'h0070);
    rd(8'h44, v); chk("R3 status read", v, {8'h0, exp_status(1, 0, 0, 0)});

    // R10 program to locked block
    wr(8'h23, 16'h0010); wr(8'h23, 16'h1234);
    chk("R10 prog locked status", {8'h0, status_o}, {8'h0, exp_status(1, 0, 1, 1)});
    wr(8'h00, 16'h00FF);
    rd(8'h23, v); chk("R10 R3 array untouched", v, 16'hFFFF);
    chk("R12 sticky after FF", {8'h0, status_o}, {8'h0, exp_status(1, 0, 1, 1)});
    wr(8'h00, 16'h0050);
    chk("R12 cleared", {8'h0, status_o}, {8'h0, exp_status(1, 0, 0, 0)});
    rd(8'h23, v); chk("R12 clear keeps array mode", v, 16'hFFFF);

    // R5 unlock block 2
    wr(8'h20, 16'h0060); wr(8'h20, 16'h00D0);
    wr(8'h00, 16'h0090);
    rd(8'h22, v); chk("R5 unlocked", v, exp_lockword(0, 0));

    // R6 R8 program with busy length
    wr(8'h23, 16'h0010); wr(8'h23, 16'h5A3C);
    wait_ready(n);
    chk("R8 program busy cycles", 16'(n), 16'(PROG_DUR));
    wr(8'h00, 16'h00FF);
    rd(8'h23, v); chk("R6 program", v, 16'h5A3C);

    // R8 read during busy, R9 write ignored while busy
    wr(8'h23, 16'h0010); wr(8'h23, 16'h0FF0);
    rd(8'h23, v); chk("R8 read while busy", v, 16'h0000);
    wr(8'h00, 16'h00FF);
    wait_ready(n);
    rd(8'h23, v); chk("R9 R8 mode still status", v, {8'h0, exp_status(1, 0, 0, 0)});
    wr(8'h00, 16'h00FF);
    rd(8'h23, v); chk("R6 AND rule", v, 16'h0A30);

    // R7 erase block 2
    wr(8'h2E, 16'h0010); wr(8'h2E, 16'h1111);
    wait_ready(n);
    wr(8'h20, 16'h0020); wr(8'h2E, 16'h00D0);
    wait_ready(n);
    chk("R8 erase busy cycles", 16'(n), 16'(ERASE_DUR));
    wr(8'h00, 16'h00FF);
    rd(8'h23, v); chk("R7 erased word", v, 16'hFFFF);
    rd(8'h2E, v); chk("R7 erased word 2", v, 16'hFFFF);

    // R11 bad confirms
    wr(8'h00, 16'h0020); wr(8'h00, 16'h0055);
    chk("R11 erase bad confirm", {8'h0, status_o}, {8'h0, exp_status(1, 1, 1, 0)});
    wr(8'h00, 16'h0050);
    chk("R11 back to idle", {8'h0, status_o}, {8'h0, exp_status(1, 0, 0, 0)});
    wr(8'h00, 16'h0060); wr(8'h00, 16'h0077);
    chk("R11 lock bad confirm", {8'h0, status_o}, {8'h0, exp_status(1, 1, 1, 0)});
    wr(8'h00, 16'h0050);

    // R10 erase locked block keeps data; R5 lock
    wr(8'h50, 16'h0060); wr(8'h50, 16'h00D0);
    wr(8'h51, 16'h0010); wr(8'h51, 16'h1234);
    wait_ready(n);
    wr(8'h50, 16'h0060); wr(8'h50, 16'h0001);
    wr(8'h00, 16'h0090);
    rd(8'h52, v); chk("R5 relocked", v, exp_lockword(1, 0));
    wr(8'h50, 16'h0020); wr(8'h50, 16'h00D0);
    chk("R10 erase locked status", {8'h0, status_o}, {8'h0, exp_status(1, 1, 0, 1)});
    wr(8'h00, 16'h00FF);
    rd(8'h51, v); chk("R10 erase locked data kept", v, 16'h1234);
    wr(8'h00, 16'h0050);

    // R5 lockdown resists unlock
    wr(8'h60, 16'h0060); wr(8'h60, 16'h002F);
    wr(8'h00, 16'h0090);
    rd(8'h62, v); chk("R5 locked down", v, exp_lockword(1, 1));
    wr(8'h60, 16'h0060); wr(8'h60, 16'h00D0);
    wr(8'h00, 16'h0090);
    rd(8'h62, v); chk("R5 lockdown keeps lock", v, exp_lockword(1, 1));
    wr(8'h00, 16'h0050);

    // Random programs and erases on blocks 8..15 (R6, R7)
    for (int b = 8; b < 16; b++) begin
      wr(8'(b << 4), 16'h0060); wr(8'(b << 4), 16'h00D0);
    end
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a;
      logic [15:0] d;
      a = {1'b1, 7'($urandom)};
      d = 16'($urandom);
      if (($urandom % 8) == 0) begin
        wr(a, 16'h0020); wr(a, 16'h00D0);
        wait_ready(n);
        for (int k = 0; k < 16; k++) mdl[{a[7:4], 4'(k)}] = 16'hFFFF;
      end else begin
        wr(a, 16'h0010); wr(a, d);
        wait_ready(n);
        mdl[a] = mdl[a] & d;
      end
    end
    wr(8'h00, 16'h00FF);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] a;
      a = {1'b1, 7'($urandom)};
      rd(a, v);
      chk("R6 R7 random readback", v, mdl[a]);
    end

    report();
    $finish;
  end
endmodule